// File: doc/BRIEF.md
# Keyed Configuration Port Front End

This block sits on a byte-wide I/O bus and exposes a bank of configuration registers through two adjacent addresses: an index port at the base address and a data port one above it. The bank stays hidden until software writes a key byte to the index port twice in succession. A different key byte, also written to the index port, hides the bank again. While the bank is hidden, the index port only listens for keys. Data-port reads return 0xFF and data-port writes have no effect.

Once the bank is open, an index-port write latches a register index. A later data-port access then acts on that register. Two registers are served locally. One is the logical-device select at index 0x07, which steers every other access toward one device. The other is a read-only identification byte at index 0x20. Every other data-port access becomes a single-cycle read or write strobe to a downstream register file. Each strobe carries the selected device number, the index and the write byte. The read byte from the register file is passed back combinationally in the same bus cycle.

Top module: `keyed_cfg_port`

## Requirements
- R1: After a synchronous active-low reset the bank is closed (`cfg_open` = 0), the device select reads back 0x00, and the latched index is 0x00.
- R2: The bank opens (`cfg_open` = 1 after the clock edge) only when the enter key is written to the index port on two index-port writes in a row. The enter key is 0x87 by default.
- R3: An index-port write of any other value between the two enter keys cancels the partial sequence, so two further enter keys are needed.
- R4: While the bank is closed, a data-port read returns 0xFF, a data-port write changes nothing, and no downstream strobe is raised.
- R5: While the bank is open, writing the leave key to the index port closes the bank. The leave key is 0xAA by default. The same byte written to the data port is ordinary register data and does not close the bank.
- R6: A data-port write while index 0x07 is selected stores the device number. A data-port read at index 0x07 returns it, and `reg_dev` presents it. Neither access raises a strobe.
- R7: A data-port read at index 0x20 returns the `CHIP_ID` parameter. A data-port write at that index is dropped without a strobe.
- R8: A data-port write at any other index raises `reg_wr_stb` for that one cycle. `reg_idx`, `reg_dev` and `reg_wdata` carry the index, device and byte during that cycle.
- R9: A data-port read at any other index raises `reg_rd_stb` for that cycle and returns `reg_rdata` on `bus_rdata`.
- R10: While the bank is open, a read of the index port returns the latched index.
- R11: With `ALT_KEYS` = 1, the enter key becomes 0x88 and the leave key becomes 0xBB. The default keys then have no unlocking or relocking effect.
- R12: Accesses at any address other than the base and the base plus one have no effect on the state, and they raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | I/O address of the current access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid in the cycle of `bus_rd` |
| cfg_open | output | 1 | Bank currently unlocked |
| reg_wr_stb | output | 1 | Downstream register write strobe |
| reg_rd_stb | output | 1 | Downstream register read strobe |
| reg_dev | output | 8 | Selected logical device number |
| reg_idx | output | 8 | Latched register index |
| reg_wdata | output | 8 | Byte for a downstream write |
| reg_rdata | input | 8 | Byte returned by the downstream register file |

## Verification
The bench builds two instances on one shared bus. The first uses the defaults: base 0x2E, keys 0x87 and 0xAA, and ID 0x52. The second uses base 0x4E, the alternate keys and ID 0xA5. Because the two instances decode different addresses, every access to one is also an access to a foreign address for the other. This puts the R12 behaviour in view throughout the run. The second instance also shows that the default keys fail to open it under the alternate setting.

// File: rtl/kcp_pkg.sv
// Shared definitions for the keyed configuration port.
// Assumes key values are fixed at build time by a single select bit.
package kcp_pkg;
    typedef enum logic [1:0] {
        KCP_LOCKED = 2'd0,
        KCP_HALF   = 2'd1,
        KCP_OPEN   = 2'd2
    } kcp_state_e;

    localparam logic [7:0] KCP_DEV_IDX = 8'h07;
    localparam logic [7:0] KCP_ID_IDX  = 8'h20;
    localparam logic [7:0] KCP_IDLE_RD = 8'hFF;

    // Enter key for the chosen key set.
    function automatic logic [7:0] kcp_enter_key(input bit alt);
        return alt ? 8'h88 : 8'h87;
    endfunction

    // Leave key for the chosen key set.
    function automatic logic [7:0] kcp_leave_key(input bit alt);
        return alt ? 8'hBB : 8'hAA;
    endfunction
endpackage

// File: rtl/kcp_addr_decode.sv
// Address match for the index and data ports.
// Assumes a read or write strobe accompanies a valid address.
module kcp_addr_decode #(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h002E
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_index,
    output logic              hit_data
);
    localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR + ADDR_W'(1);

    // Compare the address against both port locations.
    always_comb begin
        hit_index = (addr == BASE_ADDR);
        hit_data  = (addr == DATA_ADDR);
    end
endmodule

// File: rtl/kcp_unlock_fsm.sv
// Lock state machine: two enter keys in a row open, one leave key closes.
// Assumes idx_wr is a single-cycle pulse per index-port write.
module kcp_unlock_fsm
    import kcp_pkg::*;
#(
    parameter bit ALT_KEYS = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       is_open,
    output logic       leave_hit
);
    localparam logic [7:0] ENTER = kcp_enter_key(ALT_KEYS);
    localparam logic [7:0] LEAVE = kcp_leave_key(ALT_KEYS);

    kcp_state_e state_q, state_d;

    // Next-state choice from the index-port write byte.
    always_comb begin
        state_d = state_q;
        if (idx_wr) begin
            unique case (state_q)
                KCP_LOCKED: state_d = (wdata == ENTER) ? KCP_HALF : KCP_LOCKED;
                KCP_HALF:   state_d = (wdata == ENTER) ? KCP_OPEN : KCP_LOCKED;
                KCP_OPEN:   state_d = (wdata == LEAVE) ? KCP_LOCKED : KCP_OPEN;
                default:    state_d = KCP_LOCKED;
            endcase
        end
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= KCP_LOCKED;
        else        state_q <= state_d;
    end

    // Outputs seen by the decode logic.
    always_comb begin
        is_open   = (state_q == KCP_OPEN);
        leave_hit = (wdata == LEAVE);
    end
endmodule

// File: rtl/kcp_index_regs.sv
// Holds the latched register index and the logical-device select.
// Assumes the caller gates loads with the unlock state.
module kcp_index_regs (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_load,
    input  logic       dev_load,
    input  logic [7:0] wdata,
    output logic [7:0] index_q,
    output logic [7:0] dev_q
);
    // Index latch.
    always_ff @(posedge clk) begin
        if (!rst_n)        index_q <= 8'h00;
        else if (idx_load) index_q <= wdata;
    end

    // Device select register.
    always_ff @(posedge clk) begin
        if (!rst_n)        dev_q <= 8'h00;
        else if (dev_load) dev_q <= wdata;
    end
endmodule

// File: rtl/keyed_cfg_port.sv
// Keyed configuration port: index/data pair with key unlock, device
// select, ID readback and downstream strobes.
// Assumes bus_wr and bus_rd are never high together.
module keyed_cfg_port
    import kcp_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h002E,
    parameter bit                ALT_KEYS  = 1'b0,
    parameter logic [7:0]        CHIP_ID   = 8'h52
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              cfg_open,
    output logic              reg_wr_stb,
    output logic              reg_rd_stb,
    output logic [7:0]        reg_dev,
    output logic [7:0]        reg_idx,
    output logic [7:0]        reg_wdata,
    input  logic [7:0]        reg_rdata
);
    logic hit_index, hit_data, is_open, leave_hit;
    logic idx_wr, dat_wr, dat_rd, local_idx;
    logic [7:0] index_q, dev_q;

    kcp_addr_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
        .addr(bus_addr), .hit_index(hit_index), .hit_data(hit_data)
    );

    kcp_unlock_fsm #(.ALT_KEYS(ALT_KEYS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .wdata(bus_wdata),
        .is_open(is_open), .leave_hit(leave_hit)
    );

    kcp_index_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .idx_load(is_open && idx_wr && !leave_hit),
        .dev_load(dat_wr && (index_q == KCP_DEV_IDX)),
        .wdata(bus_wdata), .index_q(index_q), .dev_q(dev_q)
    );

    // Qualify bus accesses by port and, for data, by unlock state.
    always_comb begin
        idx_wr    = bus_wr && hit_index;
        dat_wr    = bus_wr && hit_data && is_open;
        dat_rd    = bus_rd && hit_data && is_open;
        local_idx = (index_q == KCP_DEV_IDX) || (index_q == KCP_ID_IDX);
    end

    // Downstream strobes and their payload.
    always_comb begin
        reg_wr_stb = dat_wr && !local_idx;
        reg_rd_stb = dat_rd && !local_idx;
        reg_dev    = dev_q;
        reg_idx    = index_q;
        reg_wdata  = bus_wdata;
        cfg_open   = is_open;
    end

    // Read-data selection.
    always_comb begin
        bus_rdata = KCP_IDLE_RD;
        if (bus_rd && hit_index && is_open) begin
            bus_rdata = index_q;
        end else if (dat_rd) begin
            if (index_q == KCP_DEV_IDX)     bus_rdata = dev_q;
            else if (index_q == KCP_ID_IDX) bus_rdata = CHIP_ID;
            else                            bus_rdata = reg_rdata;
        end
    end
endmodule

// File: rtl/keyed_cfg_port_chk.sv
// Temporal checks for keyed_cfg_port, attached by bind.
module keyed_cfg_port_chk
    import kcp_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h002E,
    parameter bit                ALT_KEYS  = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              cfg_open,
    input logic              reg_wr_stb,
    input logic              reg_rd_stb,
    input logic [7:0]        reg_dev,
    input logic [7:0]        reg_idx
);
    localparam logic [ADDR_W-1:0] DADDR = BASE_ADDR + ADDR_W'(1);
    localparam logic [7:0] ENTER = kcp_enter_key(ALT_KEYS);
    localparam logic [7:0] LEAVE = kcp_leave_key(ALT_KEYS);

    AST_LOCKED_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_open |-> !(reg_wr_stb || reg_rd_stb)); // R4
    AST_LOCKED_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && bus_rd && bus_addr == DADDR) |-> bus_rdata == 8'hFF); // R4
    AST_OPEN_AFTER_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_open) |-> $past(bus_wr && bus_addr == BASE_ADDR && bus_wdata == ENTER)); // R2
    AST_LEAVE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && bus_wr && bus_addr == BASE_ADDR && bus_wdata == LEAVE) |=> !cfg_open); // R5
    AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_wr_stb, reg_rd_stb})); // R8
    AST_DEV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == DADDR) |=> $stable(reg_dev)); // R6
    AST_LOCAL_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_idx == KCP_DEV_IDX || reg_idx == KCP_ID_IDX) |-> !(reg_wr_stb || reg_rd_stb)); // R7
endmodule

bind keyed_cfg_port keyed_cfg_port_chk #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .ALT_KEYS(ALT_KEYS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cfg_open(cfg_open), .reg_wr_stb(reg_wr_stb), .reg_rd_stb(reg_rd_stb),
    .reg_dev(reg_dev), .reg_idx(reg_idx)
);

// File: tb/test_keyed_cfg_port.sv
module test_keyed_cfg_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  a_rdata, b_rdata, a_dev, b_dev, a_idx, b_idx, a_wd, b_wd, a_rr, b_rr;
    logic        a_open, b_open, a_ws, b_ws, a_rs, b_rs;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;
    logic [7:0]  s_rdata, s_idx, s_dev, s_wd, sb_rdata;
    logic        s_ws, s_rs, sb_ws, sb_rs;

    always #2.5 clk = ~clk;

    // Downstream register file model: returns index xor 0x5A.
    assign a_rr = a_idx ^ 8'h5A;
    assign b_rr = b_idx ^ 8'h5A;

    keyed_cfg_port i_keyed_cfg_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(a_rdata), .cfg_open(a_open),
        .reg_wr_stb(a_ws), .reg_rd_stb(a_rs), .reg_dev(a_dev), .reg_idx(a_idx),
        .reg_wdata(a_wd), .reg_rdata(a_rr)
    );

    keyed_cfg_port #(.BASE_ADDR(16'h004E), .ALT_KEYS(1'b1), .CHIP_ID(8'hA5)) i_keyed_cfg_port_alt (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(b_rdata), .cfg_open(b_open),
        .reg_wr_stb(b_ws), .reg_rd_stb(b_rs), .reg_dev(b_dev), .reg_idx(b_idx),
        .reg_wdata(b_wd), .reg_rdata(b_rr)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // One bus access: drive at negedge, sample mid-cycle, release after edge.
    task automatic access(input logic [15:0] a, input logic w, input logic r, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d;
        #1;
        s_rdata = a_rdata; s_ws = a_ws; s_rs = a_rs; s_idx = a_idx; s_dev = a_dev; s_wd = a_wd;
        sb_rdata = b_rdata; sb_ws = b_ws; sb_rs = b_rs;
        @(posedge clk);
        #1;
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    // req | addr | wr | rd | wdata | exp_rdata | exp_wstb | exp_rstb | exp_open
    localparam logic [40:0] VEC [0:19] = '{
        {4'd4,  16'h002F, 1'b0, 1'b1, 8'h00, 8'hFF, 1'b0, 1'b0, 1'b0}, // R4 locked read
        {4'd4,  16'h002F, 1'b1, 1'b0, 8'h33, 8'hFF, 1'b0, 1'b0, 1'b0}, // R4 locked write
        {4'd2,  16'h002E, 1'b1, 1'b0, 8'h87, 8'hFF, 1'b0, 1'b0, 1'b0}, // R2 first key
        {4'd3,  16'h002E, 1'b1, 1'b0, 8'h11, 8'hFF, 1'b0, 1'b0, 1'b0}, // R3 cancel
        {4'd3,  16'h002E, 1'b1, 1'b0, 8'h87, 8'hFF, 1'b0, 1'b0, 1'b0}, // R3 restart
        {4'd2,  16'h002E, 1'b1, 1'b0, 8'h87, 8'hFF, 1'b0, 1'b0, 1'b1}, // R2 open
        {4'd6,  16'h002E, 1'b1, 1'b0, 8'h07, 8'hFF, 1'b0, 1'b0, 1'b1}, // R6 select index 07
        {4'd6,  16'h002F, 1'b1, 1'b0, 8'h08, 8'hFF, 1'b0, 1'b0, 1'b1}, // R6 device 08
        {4'd6,  16'h002F, 1'b0, 1'b1, 8'h00, 8'h08, 1'b0, 1'b0, 1'b1}, // R6 readback
        {4'd7,  16'h002E, 1'b1, 1'b0, 8'h20, 8'hFF, 1'b0, 1'b0, 1'b1}, // R7 index 20
        {4'd7,  16'h002F, 1'b0, 1'b1, 8'h00, 8'h52, 1'b0, 1'b0, 1'b1}, // R7 ID
        {4'd7,  16'h002F, 1'b1, 1'b0, 8'h99, 8'hFF, 1'b0, 1'b0, 1'b1}, // R7 write dropped
        {4'd7,  16'h002F, 1'b0, 1'b1, 8'h00, 8'h52, 1'b0, 1'b0, 1'b1}, // R7 ID unchanged
        {4'd10, 16'h002E, 1'b1, 1'b0, 8'hF6, 8'hFF, 1'b0, 1'b0, 1'b1}, // R10 index F6
        {4'd10, 16'h002E, 1'b0, 1'b1, 8'h00, 8'hF6, 1'b0, 1'b0, 1'b1}, // R10 index read
        {4'd8,  16'h002F, 1'b1, 1'b0, 8'hAA, 8'hFF, 1'b1, 1'b0, 1'b1}, // R8 / R5 data AA
        {4'd9,  16'h002F, 1'b0, 1'b1, 8'h00, 8'hAC, 1'b0, 1'b1, 1'b1}, // R9 downstream read
        {4'd12, 16'h0030, 1'b1, 1'b0, 8'hAA, 8'hFF, 1'b0, 1'b0, 1'b1}, // R12 foreign address
        {4'd5,  16'h002E, 1'b1, 1'b0, 8'hAA, 8'hFF, 1'b0, 1'b0, 1'b0}, // R5 leave key
        {4'd4,  16'h002F, 1'b0, 1'b1, 8'h00, 8'hFF, 1'b0, 1'b0, 1'b0}  // R4 read after relock
    };

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 open after reset", {7'd0, a_open}, 8'h00);
        chk("R1 index after reset", a_idx, 8'h00);
        chk("R1 device after reset", a_dev, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < 20; i++) begin
            logic [40:0] v;
            string tag;
            v = VEC[i];
            tag = $sformatf("R%0d vec %0d", v[40:37], i);
            access(v[36:21], v[20], v[19], v[18:11]);
            if (v[19]) chk({tag, " rdata"}, s_rdata, v[10:3]);
            chk({tag, " wstb"}, {7'd0, s_ws}, {7'd0, v[2]});
            chk({tag, " rstb"}, {7'd0, s_rs}, {7'd0, v[1]});
            chk({tag, " open"}, {7'd0, a_open}, {7'd0, v[0]});
            if (v[2] || v[1]) begin
                chk({tag, " R8 idx"}, s_idx, 8'hF6);
                chk({tag, " R8 dev"}, s_dev, 8'h08);
            end
            if (v[2]) chk({tag, " R8 wdata"}, s_wd, v[18:11]);
            chk({tag, " R12 alt unaffected"}, {6'd0, sb_ws, sb_rs}, 8'h00);
        end

        // R1: reset in the middle of an open session
        access(16'h002E, 1'b1, 1'b0, 8'h87);
        access(16'h002E, 1'b1, 1'b0, 8'h87);
        access(16'h002E, 1'b1, 1'b0, 8'h07);
        access(16'h002F, 1'b1, 1'b0, 8'h05);
        chk("R6 new device", a_dev, 8'h05);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R1 closed by reset", {7'd0, a_open}, 8'h00);
        access(16'h002F, 1'b0, 1'b1, 8'h00);
        chk("R1 read after reset", s_rdata, 8'hFF);
        access(16'h002E, 1'b1, 1'b0, 8'h87);
        access(16'h002E, 1'b1, 1'b0, 8'h87);
        access(16'h002E, 1'b1, 1'b0, 8'h07);
        access(16'h002F, 1'b0, 1'b1, 8'h00);
        chk("R1 device cleared", s_rdata, 8'h00);
        access(16'h002E, 1'b1, 1'b0, 8'hAA);
        chk("R5 relocked", {7'd0, a_open}, 8'h00);

        // R11: alternate key set on the second instance
        access(16'h004E, 1'b1, 1'b0, 8'h87);
        access(16'h004E, 1'b1, 1'b0, 8'h87);
        chk("R11 default keys rejected", {7'd0, b_open}, 8'h00);
        access(16'h004E, 1'b1, 1'b0, 8'h88);
        access(16'h004E, 1'b1, 1'b0, 8'h88);
        chk("R11 alt keys open", {7'd0, b_open}, 8'h01);
        chk("R12 base instance untouched", {7'd0, a_open}, 8'h00);
        access(16'h004E, 1'b1, 1'b0, 8'h20);
        access(16'h004F, 1'b0, 1'b1, 8'h00);
        chk("R11 alt ID", sb_rdata, 8'hA5);
        access(16'h004E, 1'b1, 1'b0, 8'hAA);
        chk("R11 default leave ignored", {7'd0, b_open}, 8'h01);
        access(16'h004E, 1'b0, 1'b1, 8'h00);
        chk("R11 AA taken as index", sb_rdata, 8'hAA);
        access(16'h004E, 1'b1, 1'b0, 8'hBB);
        chk("R11 alt leave closes", {7'd0, b_open}, 8'h00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule